// File: doc/BRIEF.md
# Page Write Self-Timed Sequencer

This block sits behind a serial memory front end that has already turned the bit stream into bytes. When the front end reports a write instruction with its start address, the sequencer collects the following data bytes into a page buffer that holds one page. It steps only the in-page offset, so the collected bytes wrap around inside the page. When chip select rises, the block checks two things: the rise must land on a byte boundary, and at least one data byte must have arrived. Only then does it start an internal programming cycle of fixed length.

During that cycle the block reports busy and forces the status byte it passes through to all ones. It ignores every new command and every new byte. On the last clock of the cycle it writes all the kept bytes of the page into the array in one wide write. It also pulses a request that clears the write-enable latch. While bytes are being collected, the block asks an outside protection check about the address of each byte. A byte whose address is protected is marked as not kept and is never written.

Top module: `page_write_seq`

## Requirements
- R1: After reset, busy, wenClear and every memWrEn bit are 0, and statusOut equals statusIn.
- R2: A write with the latch set, at least one data byte, and chip select rising on a byte boundary holds busy high for exactly CYCLE_CLKS clocks. The first byte is then found in the array at the start address.
- R3: Each captured byte advances only the low log2(PAGE_BYTES) address bits, wrapping from the last offset to offset 0. The upper (page) bits stay fixed.
- R4: With more than PAGE_BYTES data bytes, a later byte replaces the earlier byte at the same in-page offset. Only the last value at each offset is written.
- R5: If chip select rises while atByteBoundary is 0, no cycle starts and nothing is written.
- R6: If chip select rises before any data byte has been captured, no cycle starts.
- R7: A write command seen while wenLatch is 0 collects nothing and starts no cycle. After the next chip-select rise the block accepts a new command.
- R8: While busy is 1, statusOut is 8'hFF.
- R9: Each cycle produces exactly one wenClear pulse, in the same clock as the array write.
- R10: Commands, data bytes and chip-select rises that arrive while busy is 1, including on the final busy clock, are ignored.
- R11: A byte whose address had protHit = 1 when it was captured is not written. The other bytes of the same page are written.
- R12: memWrEn is nonzero only on the final clock of a busy cycle. The array is unchanged earlier in the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrCmd | input | 1 | One-clock pulse: a write instruction and its address are complete |
| cmdAddr | input | ADDR_W | Start byte address of the write |
| byteValid | input | 1 | One-clock pulse: a data byte is complete |
| byteData | input | 8 | Data byte qualified by byteValid |
| csRise | input | 1 | One-clock pulse: chip select went inactive |
| atByteBoundary | input | 1 | High when no partial byte is pending (sampled with csRise) |
| wenLatch | input | 1 | Current state of the write-enable latch |
| protAddr | output | ADDR_W | Address of the byte being captured, for the protection check |
| protHit | input | 1 | High when protAddr lies in a protected region |
| statusIn | input | 8 | Status byte from the status register |
| statusOut | output | 8 | Status byte as read: statusIn, or all ones while busy |
| busy | output | 1 | Programming cycle in progress |
| wenClear | output | 1 | One-clock request to clear the write-enable latch |
| memWrEn | output | PAGE_BYTES | Per-byte array write enables, for the final clock only |
| memPage | output | ADDR_W-log2(PAGE_BYTES) | Page number for the array write |
| memData | output | 8*PAGE_BYTES | Page data; byte k is bits 8k+7..8k |

## Verification
Two pairs of events can land in the same clock. The first pair is the last data byte and the chip-select rise. The bench raises byteValid and csRise together and expects that byte to be stored, and to count as the required data byte. The second pair is a new write command and the final, committing busy clock. The bench counts busy clocks, drives wrCmd on exactly the last one, and then sends bytes and a chip-select rise. It expects no second cycle and an untouched target address.

// File: rtl/page_write_seq_pkg.sv
package page_write_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;  // start of a write: latch page and offset, clear keep mask
    logic capture;   // store byteData at the current offset and advance it
    logic commit;    // final busy clock: drive array write enables
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DROP    = 2'd2,
    ST_BUSY    = 2'd3
  } seqState_t;

endpackage

// File: rtl/page_write_seq_ctrl.sv
module page_write_seq_ctrl
  import page_write_seq_pkg::*;
#(
  parameter int CYCLE_CLKS = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrCmd,
  input  logic       wenLatch,
  input  logic       byteValid,
  input  logic       csRise,
  input  logic       atByteBoundary,
  input  logic       anyByte,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       wenClear
);

  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(CYCLE_CLKS - 1);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] tickCnt;
  logic lastTick;

  assign lastTick = (state == ST_BUSY) && (tickCnt == LAST_TICK);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (wrCmd) begin
          if (wenLatch) begin
            strobe.loadAddr = 1'b1;
            stateNext       = ST_COLLECT;
          end else begin
            stateNext = ST_DROP;
          end
        end
      end
      ST_COLLECT: begin
        strobe.capture = byteValid;
        if (csRise) begin
          if (atByteBoundary && (anyByte || byteValid)) stateNext = ST_BUSY;
          else                                          stateNext = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (csRise) stateNext = ST_IDLE;
      end
      ST_BUSY: begin
        strobe.commit = lastTick;
        if (lastTick) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_BUSY) tickCnt <= tickCnt + 1'b1;
      else                  tickCnt <= '0;
    end
  end

  assign busy     = (state == ST_BUSY);
  assign wenClear = strobe.commit;

endmodule

// File: rtl/page_write_seq_datapath.sv
module page_write_seq_datapath
  import page_write_seq_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobe,
  input  logic [ADDR_W-1:0]          cmdAddr,
  input  logic [7:0]                 byteData,
  input  logic                       protHit,
  output logic [ADDR_W-1:0]          protAddr,
  output logic                       anyByte,
  output logic [PAGE_BYTES-1:0]      memWrEn,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] memPage,
  output logic [8*PAGE_BYTES-1:0]    memData
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]      offset;
  logic [PAGE_W-1:0]     pageReg;
  logic [PAGE_BYTES-1:0] keepMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset  <= '0;
      pageReg <= '0;
      anyByte <= 1'b0;
    end else if (strobe.loadAddr) begin
      offset  <= cmdAddr[OFF_W-1:0];
      pageReg <= cmdAddr[ADDR_W-1:OFF_W];
      anyByte <= 1'b0;
    end else if (strobe.capture) begin
      offset  <= offset + 1'b1;  // wraps inside the page
      anyByte <= 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] slotData;
    logic       slotHit;

    assign slotHit = strobe.capture && (offset == OFF_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData    <= '0;
        keepMask[g] <= 1'b0;
      end else begin
        if (strobe.loadAddr)  keepMask[g] <= 1'b0;
        else if (slotHit)     keepMask[g] <= ~protHit;
        if (slotHit)          slotData    <= byteData;
      end
    end

    assign memData[8*g +: 8] = slotData;
    assign memWrEn[g]        = strobe.commit & keepMask[g];
  end

  assign protAddr = {pageReg, offset};
  assign memPage  = pageReg;

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import page_write_seq_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrCmd,
  input  logic [ADDR_W-1:0]          cmdAddr,
  input  logic                       byteValid,
  input  logic [7:0]                 byteData,
  input  logic                       csRise,
  input  logic                       atByteBoundary,
  input  logic                       wenLatch,
  output logic [ADDR_W-1:0]          protAddr,
  input  logic                       protHit,
  input  logic [7:0]                 statusIn,
  output logic [7:0]                 statusOut,
  output logic                       busy,
  output logic                       wenClear,
  output logic [PAGE_BYTES-1:0]      memWrEn,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] memPage,
  output logic [8*PAGE_BYTES-1:0]    memData
);

  seqStrobe_t strobe;
  logic       anyByte;

  page_write_seq_ctrl #(.CYCLE_CLKS(CYCLE_CLKS)) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .wrCmd          (wrCmd),
    .wenLatch       (wenLatch),
    .byteValid      (byteValid),
    .csRise         (csRise),
    .atByteBoundary (atByteBoundary),
    .anyByte        (anyByte),
    .strobe         (strobe),
    .busy           (busy),
    .wenClear       (wenClear)
  );

  page_write_seq_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdAddr  (cmdAddr),
    .byteData (byteData),
    .protHit  (protHit),
    .protAddr (protAddr),
    .anyByte  (anyByte),
    .memWrEn  (memWrEn),
    .memPage  (memPage),
    .memData  (memData)
  );

  assign statusOut = busy ? 8'hFF : statusIn;

endmodule

// File: rtl/page_write_seq_chk.sv
module page_write_seq_chk #(
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 250000
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busy,
  input logic                  wenClear,
  input logic [PAGE_BYTES-1:0] memWrEn,
  input logic [7:0]            statusIn,
  input logic [7:0]            statusOut,
  input logic                  csRise,
  input logic                  atByteBoundary
);

  localparam int RUN_W = $clog2(CYCLE_CLKS + 1) + 1;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  p_idle_status_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> statusOut == statusIn);

  p_cycle_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    wenClear |-> runLen == RUN_W'(CYCLE_CLKS - 1));

  p_start_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise && atByteBoundary));

  p_busy_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusOut == 8'hFF);

  p_commit_with_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|memWrEn) |-> wenClear);

  p_clear_ends_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    wenClear |=> !busy);

  p_commit_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    (|memWrEn) |-> busy);

endmodule

bind page_write_seq page_write_seq_chk #(
  .PAGE_BYTES (PAGE_BYTES),
  .CYCLE_CLKS (CYCLE_CLKS)
) chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .busy           (busy),
  .wenClear       (wenClear),
  .memWrEn        (memWrEn),
  .statusIn       (statusIn),
  .statusOut      (statusOut),
  .csRise         (csRise),
  .atByteBoundary (atByteBoundary)
);

// File: tb/page_write_seq_tb.sv
module page_write_seq_tb_top;

  localparam int AW    = 10;
  localparam int PB    = 32;
  localparam int OW    = 5;
  localparam int CYC   = 20;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrCmd = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic csRise = 1'b0;
  logic atByteBoundary = 1'b0;
  logic wenLatch = 1'b0;
  logic [AW-1:0] protAddr;
  logic protHit;
  logic [7:0] statusIn = 8'h0C;
  logic [7:0] statusOut;
  logic busy, wenClear;
  logic [PB-1:0] memWrEn;
  logic [AW-OW-1:0] memPage;
  logic [8*PB-1:0] memData;

  logic protOn = 1'b0;
  logic [AW-1:0] protBase = '0;
  assign protHit = protOn && (protAddr >= protBase);

  logic [7:0] mem [DEPTH];
  int checks = 0, errors = 0;
  int clearCnt = 0, commitCnt = 0, badCommit = 0;
  bit done = 0;

  always #10 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) dut_i (
    .clk(clk), .rstN(rstN), .wrCmd(wrCmd), .cmdAddr(cmdAddr),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise),
    .atByteBoundary(atByteBoundary), .wenLatch(wenLatch),
    .protAddr(protAddr), .protHit(protHit), .statusIn(statusIn),
    .statusOut(statusOut), .busy(busy), .wenClear(wenClear),
    .memWrEn(memWrEn), .memPage(memPage), .memData(memData)
  );

  // Array model
  always @(posedge clk) begin
    if (rstN) begin
      if (wenClear) clearCnt++;
      if (|memWrEn) begin
        commitCnt++;
        if (!busy) badCommit++;
        for (int i = 0; i < PB; i++)
          if (memWrEn[i]) mem[{memPage, OW'(i)}] = memData[8*i +: 8];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [AW-1:0] a);
    wrCmd = 1'b1; cmdAddr = a;
    @(negedge clk);
    wrCmd = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    byteValid = 1'b1; byteData = d;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic endCs(input logic bnd);
    csRise = 1'b1; atByteBoundary = bnd;
    @(negedge clk);
    csRise = 1'b0; atByteBoundary = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 busy", busy, 0);
    chk(wenClear == 0, "R1 wenClear", wenClear, 0);
    chk(memWrEn == 0, "R1 memWrEn", memWrEn, 0);
    chk(statusOut == statusIn, "R1 status", statusOut, statusIn);
  endtask

  task automatic t_single();
    int n, c0, k0;
    c0 = clearCnt; k0 = commitCnt;
    wenLatch = 1'b1;
    cmd(10'h045); sendByte(8'hA5); endCs(1'b1);
    chk(busy == 1, "R2 busy start", busy, 1);
    chk(statusOut == 8'hFF, "R8 status busy", statusOut, 8'hFF);
    chk(mem[10'h045] == 8'hEE, "R12 no early write", mem[10'h045], 8'hEE);
    waitIdle(n);
    chk(n == CYC, "R2 cycle length", n, CYC);
    chk(mem[10'h045] == 8'hA5, "R2 data", mem[10'h045], 8'hA5);
    chk(clearCnt - c0 == 1, "R9 one clear", clearCnt - c0, 1);
    chk(commitCnt - k0 == 1, "R9 one commit", commitCnt - k0, 1);
    chk(statusOut == statusIn, "R8 status idle", statusOut, statusIn);
  endtask

  task automatic t_wrap();
    int n;
    cmd(10'h05E);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33); sendByte(8'h44);
    endCs(1'b1); waitIdle(n);
    chk(mem[10'h05E] == 8'h11, "R3 off30", mem[10'h05E], 8'h11);
    chk(mem[10'h05F] == 8'h22, "R3 off31", mem[10'h05F], 8'h22);
    chk(mem[10'h040] == 8'h33, "R3 wrap off0", mem[10'h040], 8'h33);
    chk(mem[10'h041] == 8'h44, "R3 wrap off1", mem[10'h041], 8'h44);
    chk(mem[10'h060] == 8'hEE, "R3 next page", mem[10'h060], 8'hEE);
  endtask

  task automatic t_overrun();
    int n;
    cmd(10'h080);
    for (int k = 0; k < 34; k++) sendByte(8'(8'h50 + k));
    endCs(1'b1); waitIdle(n);
    chk(mem[10'h080] == 8'h70, "R4 off0", mem[10'h080], 8'h70);
    chk(mem[10'h081] == 8'h71, "R4 off1", mem[10'h081], 8'h71);
    chk(mem[10'h082] == 8'h52, "R4 off2", mem[10'h082], 8'h52);
    chk(mem[10'h09F] == 8'h6F, "R4 off31", mem[10'h09F], 8'h6F);
  endtask

  task automatic t_midbyte();
    int k0;
    k0 = commitCnt;
    cmd(10'h0C0); sendByte(8'h99); endCs(1'b0);
    chk(busy == 0, "R5 no start", busy, 0);
    repeat (CYC + 2) @(negedge clk);
    chk(mem[10'h0C0] == 8'hEE, "R5 no write", mem[10'h0C0], 8'hEE);
    chk(commitCnt == k0, "R5 no commit", commitCnt, k0);
  endtask

  task automatic t_nodata();
    cmd(10'h0C1); endCs(1'b1);
    chk(busy == 0, "R6 no start", busy, 0);
    @(negedge clk);
    chk(busy == 0, "R6 still idle", busy, 0);
  endtask

  task automatic t_nowen();
    int n;
    wenLatch = 1'b0;
    cmd(10'h0C2); sendByte(8'h77); endCs(1'b1);
    chk(busy == 0, "R7 ignored", busy, 0);
    repeat (CYC + 2) @(negedge clk);
    chk(mem[10'h0C2] == 8'hEE, "R7 no write", mem[10'h0C2], 8'hEE);
    wenLatch = 1'b1;
    cmd(10'h0C3); sendByte(8'h12); endCs(1'b1);
    chk(busy == 1, "R7 back to idle", busy, 1);
    waitIdle(n);
    chk(mem[10'h0C3] == 8'h12, "R7 later write", mem[10'h0C3], 8'h12);
  endtask

  task automatic t_byteAndCs();
    int n;
    cmd(10'h100); sendByte(8'h01);
    byteValid = 1'b1; byteData = 8'h02; csRise = 1'b1; atByteBoundary = 1'b1;
    @(negedge clk);
    byteValid = 1'b0; csRise = 1'b0; atByteBoundary = 1'b0;
    chk(busy == 1, "R2 start same clock", busy, 1);
    waitIdle(n);
    chk(mem[10'h101] == 8'h02, "R3 last byte kept", mem[10'h101], 8'h02);
    chk(mem[10'h100] == 8'h01, "R2 first byte", mem[10'h100], 8'h01);
  endtask

  task automatic t_busyCollide();
    int n, k0;
    cmd(10'h140); sendByte(8'h5A); endCs(1'b1);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 5) begin byteValid = 1'b1; byteData = 8'hBB; end
      if (n == CYC) begin wrCmd = 1'b1; cmdAddr = 10'h180; end
      @(negedge clk);
      byteValid = 1'b0; wrCmd = 1'b0;
    end
    k0 = commitCnt;
    sendByte(8'h66); endCs(1'b1);
    chk(busy == 0, "R10 no restart", busy, 0);
    repeat (CYC + 2) @(negedge clk);
    chk(commitCnt == k0, "R10 no commit", commitCnt, k0);
    chk(mem[10'h180] == 8'hEE, "R10 cmd ignored", mem[10'h180], 8'hEE);
    chk(mem[10'h140] == 8'h5A, "R10 data intact", mem[10'h140], 8'h5A);
    chk(mem[10'h141] == 8'hEE, "R10 byte ignored", mem[10'h141], 8'hEE);
  endtask

  task automatic t_protect();
    int n;
    protOn = 1'b1; protBase = 10'h1D0;
    cmd(10'h1CE);
    sendByte(8'hA1); sendByte(8'hA2); sendByte(8'hA3); sendByte(8'hA4);
    endCs(1'b1); waitIdle(n);
    protOn = 1'b0;
    chk(mem[10'h1CE] == 8'hA1, "R11 open byte", mem[10'h1CE], 8'hA1);
    chk(mem[10'h1CF] == 8'hA2, "R11 open byte", mem[10'h1CF], 8'hA2);
    chk(mem[10'h1D0] == 8'hEE, "R11 protected", mem[10'h1D0], 8'hEE);
    chk(mem[10'h1D1] == 8'hEE, "R11 protected", mem[10'h1D1], 8'hEE);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overrun();
    t_midbyte();
    t_nodata();
    t_nowen();
    t_byteAndCs();
    t_busyCollide();
    t_protect();
    chk(clearCnt == 7, "R9 clear per cycle", clearCnt, 7);
    chk(badCommit == 0, "R12 commit outside busy", badCommit, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule